// File: doc/BRIEF.md
# I2C Port-Expander Register Target

This block is the serial side of an 8-bit general-purpose I/O expander. It watches the two I2C lines through a synchronizer clocked by a faster system clock. It answers one 7-bit address, built from a fixed prefix and three strap pins. It holds a register pointer that a command byte sets, and it returns the selected register byte by byte for as long as the controller keeps acknowledging.

A typical register read has four steps. The controller writes the address with the direction bit clear, then sends a command byte, then issues a repeated start, then addresses the target again with the direction bit set. The pointer survives the restart. Every byte of a read comes from the same register. When that register is the input port, the pins are sampled again for every byte. Data bytes written after the command byte update the writable registers, and the block presents those registers as outputs.

SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Top module: `exp_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 0111 followed by `strap[2]`, `strap[1]`, `strap[0]`; bit 0 of that byte is the direction bit, with 1 meaning read. For any other address it never pulls SDA low until the next start or stop.
- R2: After a matching address with the direction bit clear, the target acknowledges the command byte and every data byte that follows. An acknowledge is SDA held low during the ninth clock of a byte.
- R3: Bits 1:0 of the command byte select the register: 0 is the input port, 1 is the output port, 2 is polarity inversion and 3 is configuration. A data byte written with selection 1, 2 or 3 is stored in that register. A data byte written with selection 0 changes no register.
- R4: The register pointer changes only when a command byte is received. It is kept across a repeated start and across a stop.
- R5: Successive bytes of one read all return the selected register; the pointer does not increment.
- R6: The input-port register is captured as `pins` XOR the polarity register. Capture happens on the rising SCL edge of the acknowledge clock that comes before each read byte: the address acknowledge for the first byte, and the controller's acknowledge for each later byte. Pin changes at other times do not affect the byte being sent.
- R7: After the controller leaves a read byte unacknowledged (SDA high in the ninth clock), the target releases SDA and stays off the bus until the next start or stop.
- R8: A stop (SDA rising while SCL is high) returns the target to idle from any point in a transfer. A start or repeated start (SDA falling while SCL is high) begins a new address phase from any point.
- R9: `sda_oe` changes only while SCL is low, so the target never creates a start or a stop on the bus.
- R10: After reset the output register is 0xFF, the polarity register is 0x00, the configuration register is 0xFF, and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low; low to leave it released |
| strap | input | 3 | Address strap pins forming the low three address bits |
| pins | input | 8 | Input port pin levels |
| out_reg | output | 8 | Output port register |
| pol_reg | output | 8 | Polarity inversion register |
| cfg_reg | output | 8 | Configuration register |

## Verification
Suppose the pointer is corrupted, or incremented between bytes. The very next read byte then carries another register's value, and that shows at the bit-sampling points of that byte. Suppose the input port is captured at the wrong moment. A pin change placed between the capture edge and the following byte then shows up in the wrong byte of a multi-byte read. A byte engine that drifts by one bit shows as a missing or extra acknowledge on the ninth clock of the same byte. A lost stop or start shows in the next transfer, as a refused address or a write to the wrong register.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int SEL_W   = 2;
  localparam int REG_CNT = 1 << SEL_W;

  localparam int REG_IN  = 0;
  localparam int REG_OUT = 1;
  localparam int REG_POL = 2;
  localparam int REG_CFG = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } state_t;

  function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
    return (idx == REG_POL) ? '0 : '1;
  endfunction
endpackage

// File: rtl/exp_bus_sync.sv
module exp_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES:0] sda_pipe_q, sda_pipe_d;
  logic            scl_prev, sda_prev;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-1:0], scl_raw};
    sda_pipe_d = {sda_pipe_q[STAGES-1:0], sda_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  assign scl_s    = scl_pipe_q[STAGES-1];
  assign sda_s    = sda_pipe_q[STAGES-1];
  assign scl_prev = scl_pipe_q[STAGES];
  assign sda_prev = sda_pipe_q[STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/exp_regfile.sv
module exp_regfile
  import exp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] pins,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] out_reg,
  output logic [BYTE_W-1:0] pol_reg,
  output logic [BYTE_W-1:0] cfg_reg
);
  logic [BYTE_W-1:0] bank [REG_CNT];
  logic [BYTE_W-1:0] in_q, in_d;

  always_comb in_d = pins ^ bank[REG_POL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_q <= '0;
    else if (cap_en) in_q <= in_d;
  end

  assign bank[REG_IN] = in_q;

  for (genvar g = 1; g < REG_CNT; g++) begin : g_wreg
    logic [BYTE_W-1:0] q;
    logic              en;
    assign en = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= reg_reset(g);
      else if (en) q <= wr_data;
    end
    assign bank[g] = q;
  end

  assign rd_data = bank[rd_sel];
  assign out_reg = bank[REG_OUT];
  assign pol_reg = bank[REG_POL];
  assign cfg_reg = bank[REG_CFG];

  // R3
  reg_in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(REG_IN)) |=>
      ($stable(bank[REG_OUT]) && $stable(bank[REG_POL]) && $stable(bank[REG_CFG])));

  // R6
  input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(in_q));
endmodule

// File: rtl/exp_target_fsm.sv
module exp_target_fsm
  import exp_pkg::*;
#(
  parameter int                        STRAP_W     = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic [SEL_W-1:0]   rd_sel,
  output logic               wr_en,
  output logic [SEL_W-1:0]   wr_sel,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               cap_en,
  output logic               sda_oe
);
  localparam int          CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

  state_t             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  rx_q, rx_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic [SEL_W-1:0]   ptr_q, ptr_d;
  logic               rw_q, rw_d;
  logic               oe_q, oe_d;
  logic               ack_q, ack_d;
  logic               rx_state, byte_full, addr_hit;

  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_WDATA);
  assign byte_full = (cnt_q == FULL);
  assign addr_hit  = (rx_q[BYTE_W-1:1] == {ADDR_PREFIX, strap});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    ack_d   = ack_q;
    wr_en   = 1'b0;
    cap_en  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else begin
      if (rx_state && scl_rise && !byte_full) begin
        rx_d  = {rx_q[BYTE_W-2:0], sda_s};
        cnt_d = cnt_q + 1'b1;
      end
      case (state_q)
        ST_ADDR: begin
          if (scl_fall && byte_full) begin
            cnt_d = '0;
            if (addr_hit) begin
              rw_d    = rx_q[0];
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_rise) cap_en = 1'b1;
          if (scl_fall) begin
            if (rw_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (scl_fall && byte_full) begin
            cnt_d   = '0;
            ptr_d   = rx_q[SEL_W-1:0];
            oe_d    = 1'b1;
            state_d = ST_CMD_ACK;
          end
        end
        ST_WDATA: begin
          if (scl_fall && byte_full) begin
            cnt_d   = '0;
            wr_en   = 1'b1;
            oe_d    = 1'b1;
            state_d = ST_WDATA_ACK;
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~tx_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d  = ~sda_s;
            cap_en = 1'b1;
          end
          if (scl_fall) begin
            if (ack_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      ack_q   <= ack_d;
    end
  end

  assign rd_sel  = ptr_q;
  assign wr_sel  = ptr_q;
  assign wr_data = rx_q;
  assign sda_oe  = oe_q;

  // R1
  addr_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_fall && byte_full && !addr_hit && !start_det && !stop_det)
      |=> (!oe_q && state_q == ST_IGNORE));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CMD) |=> $stable(ptr_q));

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK && scl_fall && !ack_q) |=> (!oe_q && state_q == ST_IGNORE));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q));

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);
endmodule

// File: rtl/exp_i2c_target.sv
module exp_i2c_target
  import exp_pkg::*;
#(
  parameter int                        STRAP_W     = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b0111,
  parameter int                        SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  pins,
  output logic [BYTE_W-1:0]  out_reg,
  output logic [BYTE_W-1:0]  pol_reg,
  output logic [BYTE_W-1:0]  cfg_reg
);
  logic              rst_meta_q, rst_sync_q;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [SEL_W-1:0]  rd_sel, wr_sel;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic              wr_en, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  exp_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  exp_target_fsm #(.STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap),
    .rd_data   (rd_data),
    .rd_sel    (rd_sel),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cap_en    (cap_en),
    .sda_oe    (sda_oe)
  );

  exp_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cap_en  (cap_en),
    .pins    (pins),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .out_reg (out_reg),
    .pol_reg (pol_reg),
    .cfg_reg (cfg_reg)
  );
endmodule

// File: tb/exp_i2c_target_test.sv
module exp_i2c_target_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl;
  logic       m_low;
  logic [2:0] strap;
  logic [7:0] pins;
  logic       sda_oe;
  logic [7:0] out_reg, pol_reg, cfg_reg;
  wire        sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  exp_i2c_target uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .strap   (strap),
    .pins    (pins),
    .out_reg (out_reg),
    .pol_reg (pol_reg),
    .cfg_reg (cfg_reg)
  );

  int checks = 0;
  int errors = 0;
  int r9_viol = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;
  item_t      exp_q[$];
  logic [7:0] got;
  event       got_ev;

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: no expected item, actual %h", got);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (got !== it.v) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, got, it.v);
        end
      end
    end
  end

  // R9 watcher: sda_oe must not move while SCL is high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== prev_oe && m_scl) r9_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    b = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_low = 1'b0; wq(); wq();
  endtask

  // exp_ack = 1 means the target should pull SDA low in the ninth clock
  task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic bit_v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    exp_q.push_back('{v: {7'd0, ~exp_ack}, tag: tag});
    recv_bit(bit_v);
    got = {7'd0, bit_v};
    ->got_ev;
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic m_ack,
                           input logic [7:0] pins_start, input logic [7:0] pins_ack,
                           input string tag);
    logic [7:0] val;
    logic       bit_v;
    pins = pins_start;
    exp_q.push_back('{v: exp, tag: tag});
    for (int i = 7; i >= 0; i--) begin
      recv_bit(bit_v);
      val[i] = bit_v;
    end
    got = val;
    ->got_ev;
    pins = pins_ack;
    send_bit(~m_ack);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (R8 bus hang), actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_low = 1'b0;
    strap = 3'b101;
    pins  = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 out_reg", out_reg, 8'hFF);
    chk("R10 pol_reg", pol_reg, 8'h00);
    chk("R10 cfg_reg", cfg_reg, 8'hFF);
    chk("R10 sda_oe", {7'd0, sda_oe}, 8'h00);

    // writes to each writable register (address 0x3D -> 0x7A write, 0x7B read)
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h02, 1'b1, "R2 command ack");
    write_byte(8'h0F, 1'b1, "R2 data ack");
    bus_stop();
    chk("R3 polarity written", pol_reg, 8'h0F);

    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h01, 1'b1, "R2 command ack");
    write_byte(8'h55, 1'b1, "R2 data ack");
    bus_stop();
    chk("R3 output written", out_reg, 8'h55);

    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h03, 1'b1, "R2 command ack");
    write_byte(8'hA0, 1'b1, "R2 data ack");
    write_byte(8'hA6, 1'b1, "R2 second data ack");
    bus_stop();
    chk("R3 config written", cfg_reg, 8'hA6);

    // write to the input register is ignored
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h00, 1'b1, "R2 command ack");
    write_byte(8'h33, 1'b1, "R2 data ack reg0");
    bus_stop();
    chk("R3 reg0 write, out unchanged", out_reg, 8'h55);
    chk("R3 reg0 write, pol unchanged", pol_reg, 8'h0F);
    chk("R3 reg0 write, cfg unchanged", cfg_reg, 8'hA6);

    // input port read with repeated start and resampling
    pins = 8'hC3;
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h00, 1'b1, "R2 command ack");
    bus_start();
    write_byte(8'h7B, 1'b1, "R1 read address ack");
    read_byte(8'hCC, 1'b1, 8'h99, 8'h12, "R6 first byte captured at address ack");
    read_byte(8'h1D, 1'b0, 8'h77, 8'h77, "R6 second byte captured at controller ack");
    read_byte(8'hFF, 1'b0, 8'h00, 8'h00, "R7 SDA released after NACK");
    bus_stop();
    chk("R7 sda_oe low after NACK", {7'd0, sda_oe}, 8'h00);

    // pointer set by a command-only write, kept across stop, no increment
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h02, 1'b1, "R2 command ack");
    bus_stop();
    bus_start();
    write_byte(8'h7B, 1'b1, "R1 read address ack");
    read_byte(8'h0F, 1'b1, 8'h00, 8'h00, "R4 pointer kept across stop");
    read_byte(8'h0F, 1'b1, 8'h00, 8'h00, "R5 no increment byte 2");
    read_byte(8'h0F, 1'b0, 8'h00, 8'h00, "R5 no increment byte 3");
    bus_stop();

    // pointer across repeated start for output and config registers
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'h01, 1'b1, "R2 command ack");
    bus_start();
    write_byte(8'h7B, 1'b1, "R1 read address ack");
    read_byte(8'h55, 1'b0, 8'h00, 8'h00, "R4 output register after restart");
    bus_stop();
    bus_start();
    write_byte(8'h7A, 1'b1, "R1 address ack");
    write_byte(8'hFF, 1'b1, "R3 command bits 1:0 = 3");
    bus_start();
    write_byte(8'h7B, 1'b1, "R1 read address ack");
    read_byte(8'hA6, 1'b0, 8'h00, 8'h00, "R3 config read via high command bits");
    bus_stop();

    // non-matching address: target stays off the bus
    bus_start();
    write_byte(8'h7C, 1'b0, "R1 wrong strap bits not acked");
    write_byte(8'h00, 1'b0, "R1 stays off bus after miss");
    bus_stop();
    bus_start();
    write_byte(8'hFA, 1'b0, "R1 wrong prefix not acked");
    bus_stop();
    chk("R1 out unchanged after miss", out_reg, 8'h55);

    // strap change to 000 -> address 0x38
    strap = 3'b000;
    bus_start();
    write_byte(8'h7A, 1'b0, "R1 old address refused");
    bus_stop();
    bus_start();
    write_byte(8'h70, 1'b1, "R1 new strap address ack");
    write_byte(8'h02, 1'b1, "R2 command ack");
    write_byte(8'h00, 1'b1, "R2 data ack");
    bus_stop();
    chk("R3 polarity cleared", pol_reg, 8'h00);

    // stop in the middle of a command byte
    bus_start();
    write_byte(8'h70, 1'b1, "R1 address ack");
    send_bits(8'h01, 4);
    bus_stop();
    chk("R8 sda_oe low after mid-byte stop", {7'd0, sda_oe}, 8'h00);

    // start in the middle of a command byte, then read: pointer still 2
    pins = 8'h5A;
    bus_start();
    write_byte(8'h70, 1'b1, "R8 address ack after stop");
    send_bits(8'h01, 3);
    bus_start();
    write_byte(8'h71, 1'b1, "R8 read address ack after restart");
    read_byte(8'h00, 1'b0, 8'h00, 8'h00, "R4 pointer unchanged by aborted command");
    bus_stop();

    // input port with cleared polarity
    bus_start();
    write_byte(8'h70, 1'b1, "R1 address ack");
    write_byte(8'h00, 1'b1, "R2 command ack");
    pins = 8'h96;
    bus_start();
    write_byte(8'h71, 1'b1, "R1 read address ack");
    read_byte(8'h96, 1'b0, 8'h00, 8'h00, "R6 input with zero polarity");
    bus_stop();

    chk("R9 sda_oe changes while SCL high", r9_viol[7:0], 8'h00);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule